// File: doc/BRIEF.md
# Processor Mode and Size Decoder

This block turns a handful of architectural control bits into one registered status word. The word gives the current execution mode (legacy or long), a finer submode (real, protected, virtual-8086, compatibility or 64-bit), the current privilege level, and paging and protection flags. It also gives three pairs of size codes: operand size (default and alternate), address size (default and alternate), and stack size.

The control bits come from state held elsewhere: the long-mode-active bit, the protection-enable and paging-enable bits of the main control register, the virtual-8086 flag, and the code- and stack-segment attributes. Whoever owns that state pulses `recompute` after changing any of these bits. The decoder then captures a fresh word on that clock edge and holds it until the next pulse. Instruction decode logic can read the word directly without re-deriving the mode on every access.

Top module: `pmsd_status`

## Requirements
- R1: While `rst_n` is low the status word is all zeros, and it stays all zeros after reset until the first `recompute` pulse.
- R2: The word changes only on a rising clock edge where `recompute` is high. On that edge it loads values computed from the inputs sampled at the same edge. On every other edge it keeps its value whatever the inputs do.
- R3: Field layout of `status`: bit 17 is mode, bits 16:14 are submode, bits 13:12 are privilege level, bit 11 is paging, bit 10 is protection, bits 9:8 are default operand size, bits 7:6 are alternate operand size, bits 5:4 are default address size, bits 3:2 are alternate address size, and bits 1:0 are stack size.
- R4: With `lma` set, mode is 1 (long). Submode is 4 (64-bit) if `cs_long` is set, and 3 (compatibility) if it is clear.
- R5: With `lma` clear, mode is 0 (legacy). Submode is 0 (real) if `cr0_pe` is clear, 2 (virtual-8086) if `cr0_pe` and `rflags_vm` are both set, and 1 (protected) otherwise.
- R6: The privilege level field equals `cs_dpl`, the paging field equals `cr0_pg`, and the protection field equals `cr0_pe`.
- R7: Size codes are 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Code 0 never appears after a recompute. The operand sizes are default 2 / alternate 1 when the submode is 64-bit or `cs_dsize` is set, and default 1 / alternate 2 otherwise.
- R8: The address sizes are default 3 / alternate 2 in 64-bit submode. Outside that submode they are default 2 / alternate 1 when `cs_dsize` is set, and default 1 / alternate 2 when it is clear.
- R9: The stack size is 3 in 64-bit submode. Outside that submode it is 2 when `ss_dsize` is set and 1 when it is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recompute | input | 1 | Strobe that loads a new status word |
| lma | input | 1 | Long mode active |
| cr0_pe | input | 1 | Protection enable |
| cr0_pg | input | 1 | Paging enable |
| rflags_vm | input | 1 | Virtual-8086 flag |
| cs_long | input | 1 | Code segment 64-bit attribute |
| cs_dsize | input | 1 | Code segment default-size attribute |
| cs_dpl | input | 2 | Code segment privilege level |
| ss_dsize | input | 1 | Stack segment default-size attribute |
| status | output | 18 | Registered mode and size word |

## Verification
Several corner cases get targeted tests. One sets `cs_long` while long mode is inactive; a design that trusts that bit alone would report 64-bit sizes in legacy mode. One sets `rflags_vm` with protection off; a design that checks VM before PE would report virtual-8086 instead of real mode. One sets `cs_dsize` and `ss_dsize` in 64-bit submode; a design with the wrong priority would emit 32-bit address and stack codes. Hold cycles change every input with the strobe low, so a design that loads without the strobe is caught. A sweep of all 512 input combinations then catches any swapped default/alternate pair or stray zero code.

// File: rtl/pmsd_pkg.sv
package pmsd_pkg;

    localparam int unsigned SZ_W    = 2;
    localparam int unsigned CPL_W   = 2;
    localparam int unsigned SUB_W   = 3;
    localparam int unsigned STATUS_W = 1 + SUB_W + CPL_W + 2 + 5 * SZ_W;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_LONG   = 1'b1
    } cpu_mode_e;

    typedef enum logic [SUB_W-1:0] {
        SUB_REAL   = 3'd0,
        SUB_PROT   = 3'd1,
        SUB_V86    = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_WIDE64 = 3'd4
    } cpu_sub_e;

    typedef enum logic [SZ_W-1:0] {
        SZ_NONE = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_64   = 2'd3
    } size_code_e;

    typedef struct packed {
        size_code_e def_op;
        size_code_e alt_op;
        size_code_e def_addr;
        size_code_e alt_addr;
        size_code_e stack;
    } size_set_t;

    typedef struct packed {
        cpu_mode_e         mode;
        cpu_sub_e          sub;
        logic [CPL_W-1:0]  cpl;
        logic              paging;
        logic              prot;
        size_set_t         sizes;
    } status_t;

endpackage

// File: rtl/pmsd_mode_classify.sv
module pmsd_mode_classify
    import pmsd_pkg::*;
(
    input  logic      lma,
    input  logic      prot_en,
    input  logic      vm_flag,
    input  logic      cs_long,
    output cpu_mode_e mode,
    output cpu_sub_e  sub,
    output logic      is_wide
);

    always_comb begin
        if (lma) begin
            mode = MODE_LONG;
            sub  = cs_long ? SUB_WIDE64 : SUB_COMPAT;
        end else begin
            mode = MODE_LEGACY;
            if (!prot_en) begin
                sub = SUB_REAL;
            end else if (vm_flag) begin
                sub = SUB_V86;
            end else begin
                sub = SUB_PROT;
            end
        end
        is_wide = (sub == SUB_WIDE64);
    end

endmodule

// File: rtl/pmsd_size_encode.sv
module pmsd_size_encode
    import pmsd_pkg::*;
(
    input  logic      is_wide,
    input  logic      cs_dsize,
    input  logic      ss_dsize,
    output size_set_t sizes
);

    always_comb begin
        // operand width: 64-bit submode behaves like a 32-bit default code segment
        if (is_wide || cs_dsize) begin
            sizes.def_op = SZ_32;
            sizes.alt_op = SZ_16;
        end else begin
            sizes.def_op = SZ_16;
            sizes.alt_op = SZ_32;
        end

        // address width: 64-bit submode overrides the segment attribute
        if (is_wide) begin
            sizes.def_addr = SZ_64;
            sizes.alt_addr = SZ_32;
        end else if (cs_dsize) begin
            sizes.def_addr = SZ_32;
            sizes.alt_addr = SZ_16;
        end else begin
            sizes.def_addr = SZ_16;
            sizes.alt_addr = SZ_32;
        end

        // stack width
        if (is_wide) begin
            sizes.stack = SZ_64;
        end else if (ss_dsize) begin
            sizes.stack = SZ_32;
        end else begin
            sizes.stack = SZ_16;
        end
    end

endmodule

// File: rtl/pmsd_status.sv
module pmsd_status
    import pmsd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  recompute,
    input  logic                  lma,
    input  logic                  cr0_pe,
    input  logic                  cr0_pg,
    input  logic                  rflags_vm,
    input  logic                  cs_long,
    input  logic                  cs_dsize,
    input  logic [CPL_W-1:0]      cs_dpl,
    input  logic                  ss_dsize,
    output logic [STATUS_W-1:0]   status
);

    cpu_mode_e mode_w;
    cpu_sub_e  sub_w;
    logic      wide_w;
    size_set_t sizes_w;

    status_t   word_d;
    status_t   word_q;

    pmsd_mode_classify u_mode (
        .lma     (lma),
        .prot_en (cr0_pe),
        .vm_flag (rflags_vm),
        .cs_long (cs_long),
        .mode    (mode_w),
        .sub     (sub_w),
        .is_wide (wide_w)
    );

    pmsd_size_encode u_size (
        .is_wide  (wide_w),
        .cs_dsize (cs_dsize),
        .ss_dsize (ss_dsize),
        .sizes    (sizes_w)
    );

    always_comb begin
        word_d = word_q;
        if (recompute) begin
            word_d.mode   = mode_w;
            word_d.sub    = sub_w;
            word_d.cpl    = cs_dpl;
            word_d.paging = cr0_pg;
            word_d.prot   = cr0_pe;
            word_d.sizes  = sizes_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign status = word_q;

endmodule

// File: rtl/pmsd_status_chk.sv
module pmsd_status_chk
    import pmsd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                recompute,
    input logic                lma,
    input logic                cr0_pe,
    input logic                cs_long,
    input logic [CPL_W-1:0]    cs_dpl,
    input logic                ss_dsize,
    input logic [STATUS_W-1:0] status
);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !recompute |=> $stable(status));

    assert_long_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && lma) |=> (status[17] == 1'b1) &&
            (status[16:14] == ($past(cs_long) ? 3'd4 : 3'd3)));

    assert_real_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && !lma && !cr0_pe) |=> (status[17] == 1'b0) && (status[16:14] == 3'd0));

    assert_cpl_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recompute |=> (status[13:12] == $past(cs_dpl)));

    assert_no_zero_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recompute |=> (status[9:8] != 2'd0) && (status[7:6] != 2'd0) &&
            (status[5:4] != 2'd0) && (status[3:2] != 2'd0) && (status[1:0] != 2'd0));

    assert_wide_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && lma && cs_long) |=> (status[1:0] == 2'd3));

    assert_narrow_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && !lma && !ss_dsize) |=> (status[1:0] == 2'd1));

endmodule

bind pmsd_status pmsd_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .recompute (recompute),
    .lma       (lma),
    .cr0_pe    (cr0_pe),
    .cs_long   (cs_long),
    .cs_dpl    (cs_dpl),
    .ss_dsize  (ss_dsize),
    .status    (status)
);

// File: tb/pmsd_status_tb.sv
`timescale 1ns/1ps
module pmsd_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recompute = 1'b0;
    logic        lma = 1'b0, cr0_pe = 1'b0, cr0_pg = 1'b0, rflags_vm = 1'b0;
    logic        cs_long = 1'b0, cs_dsize = 1'b0, ss_dsize = 1'b0;
    logic [1:0]  cs_dpl = 2'd0;
    logic [17:0] status;

    int total = 0;
    int bad = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];
    logic [17:0] last_exp = '0;

    always #2 clk = ~clk;

    pmsd_status u_dut (
        .clk (clk), .rst_n (rst_n), .recompute (recompute),
        .lma (lma), .cr0_pe (cr0_pe), .cr0_pg (cr0_pg), .rflags_vm (rflags_vm),
        .cs_long (cs_long), .cs_dsize (cs_dsize), .cs_dpl (cs_dpl),
        .ss_dsize (ss_dsize), .status (status)
    );

    // independent model of the requirements
    function automatic logic [17:0] model(input logic [8:0] v);
        logic l, pe, pg, vm, cl, cd, sd;
        logic [1:0] dpl, dop, aop, dad, aad, stk;
        logic [2:0] sub;
        l = v[8]; pe = v[7]; pg = v[6]; vm = v[5]; cl = v[4]; cd = v[3];
        dpl = v[2:1]; sd = v[0];
        if (l) sub = cl ? 3'd4 : 3'd3;
        else if (!pe) sub = 3'd0;
        else sub = vm ? 3'd2 : 3'd1;
        if (sub == 3'd4 || cd) begin dop = 2'd2; aop = 2'd1; end
        else begin dop = 2'd1; aop = 2'd2; end
        if (sub == 3'd4) begin dad = 2'd3; aad = 2'd2; end
        else if (cd) begin dad = 2'd2; aad = 2'd1; end
        else begin dad = 2'd1; aad = 2'd2; end
        stk = (sub == 3'd4) ? 2'd3 : (sd ? 2'd2 : 2'd1);
        return {l, sub, dpl, pg, pe, dop, aop, dad, aad, stk};
    endfunction

    task automatic drive(input logic strobe, input logic [8:0] v, input string tag);
        @(negedge clk);
        recompute = strobe;
        {lma, cr0_pe, cr0_pg, rflags_vm, cs_long, cs_dsize, cs_dpl, ss_dsize} = v;
        if (strobe) last_exp = model(v);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    // monitor: one item per driven cycle, compared just after the capturing edge
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            logic [17:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            #1;
            total++;
            if (status !== e) begin
                bad++;
                $display("FAIL %s: status=%h expected=%h", t, status, e);
            end
        end
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: no finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (status !== 18'h0) begin
            bad++;
            $display("FAIL R1 reset: status=%h expected=%h", status, 18'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (status !== 18'h0) begin
            bad++;
            $display("FAIL R1 after reset: status=%h expected=%h", status, 18'h0);
        end
        // R2: inputs change, no strobe, word must stay zero
        drive(1'b0, 9'h1FF, "R2 hold before first strobe");
        // R5 real mode, VM set but PE clear
        drive(1'b1, {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd3,1'b0}, "R5 real with vm");
        drive(1'b1, {1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,2'd3,1'b1}, "R5 v86");
        drive(1'b1, {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd1,1'b1}, "R5 protected 32-bit");
        // R4 cs_long without lma stays legacy
        drive(1'b1, {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0}, "R4 cs_long ignored in legacy");
        drive(1'b1, {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'd2,1'b0}, "R4 compatibility 16-bit");
        drive(1'b1, {1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'd0,1'b1}, "R8 R9 64-bit overrides dsize");
        drive(1'b1, {1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'd3,1'b0}, "R7 64-bit operand");
        drive(1'b1, {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd2,1'b1}, "R6 R3 fields");
        // R2 hold: change every input with strobe low
        drive(1'b0, {1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'd1,1'b0}, "R2 hold");
        drive(1'b0, 9'h000, "R2 hold");
        // full sweep
        for (int i = 0; i < 512; i++) begin
            drive(1'b1, i[8:0], "R4 R5 R6 R7 R8 R9 sweep");
        end
        @(negedge clk);
        recompute = 1'b0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule